// File: doc/BRIEF.md
# Narrow-Mode Bus Beat Sequencer

This block turns one aligned processor memory write request into bus beats on a 64-bit data bus that runs in 32-bit mode. Only the upper half of the bus, byte lanes 0 to 3, carries data. Byte, half-word and word requests each take a single beat. A double word is split into two 4-lane beats.

For each beat the block drives a 3-bit size code, the address, eight byte-lane enables and write data placed on the active lanes. It holds every beat output steady until the bus acknowledges the beat. After the last acknowledge it gives a one-cycle done pulse. A request whose address does not fit its size is refused with a one-cycle error pulse and produces no beat.

Lane k is enabled by `bus_lane_en[k]` and carries `bus_wdata[63-8k -: 8]`, so lane 0 holds the most significant byte. The request size input is encoded as 0 for byte, 1 for half word, 2 for word and 3 for double word.

Top module: `narrow_beat_seq`

## Requirements
- R1: `bus_tsiz` is 001 for a byte, 010 for a half word, 100 for a word, and 000 on both beats of a double word.
- R2: `bus_lane_en[7:4]` is never set, and inactive lanes carry zero data. While no beat is active all lane enables are zero.
- R3: A byte request enables only lane `addr[1:0]`, whatever the value of `addr[2]`. That lane carries `req_wdata[7:0]`, and `bus_addr` equals the request address.
- R4: A half-word request enables lanes 0–1 when `addr[1]`=0 and lanes 2–3 when `addr[1]`=1. `req_wdata[15:8]` goes on the lower-numbered lane and `req_wdata[7:0]` on the higher one.
- R5: A word request at an address ending in 000 or 100 enables lanes 0–3. `req_wdata[31:24]` goes on lane 0, and so on down to `req_wdata[7:0]` on lane 3.
- R6: A double word takes exactly two beats. Each beat enables lanes 0–3 and drives `bus_addr[2:0]`=000. The first beat carries `req_wdata[63:32]` and the second carries `req_wdata[31:0]`, in lane order as in R5.
- R7: The first beat appears in the cycle after the request is accepted. All beat outputs stay unchanged until `bus_ack` is sampled high on a clock edge while `bus_valid` is high.
- R8: `done` is high for exactly the one cycle after the final acknowledge. In that cycle `bus_valid` is low and `ready` is high.
- R9: A misaligned request raises `err` for one cycle, produces no beat and leaves `ready` high. Misaligned means `addr[0]`≠0 for a half word, `addr[1:0]`≠0 for a word, or `addr[2:0]`≠0 for a double word.
- R10: `ready` is high only while idle. It is high after reset, and low from the cycle after acceptance until the final acknowledge. A request presented while `ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_size | input | 2 | 0 byte, 1 half word, 2 word, 3 double word |
| req_addr | input | AW (32) | Byte address of the request |
| req_wdata | input | DW (64) | Write data, right-aligned for sizes below a double word |
| ready | output | 1 | Block idle and able to accept a request |
| bus_valid | output | 1 | A beat is being driven |
| bus_tsiz | output | 3 | Size code of the beat |
| bus_addr | output | AW (32) | Beat address |
| bus_lane_en | output | LANES (8) | Byte-lane enables, bit k for lane k |
| bus_wdata | output | DW (64) | Beat data, lane k at bits 63-8k down to 56-8k |
| bus_ack | input | 1 | Acknowledge for the current beat |
| done | output | 1 | One-cycle pulse after the final acknowledge |
| err | output | 1 | One-cycle pulse for a refused misaligned request |

## Verification
Bytes are sent at all eight low addresses. Pairs that differ only in `addr[2]` must pick the same lane, which separates correct two-bit lane selection from a decode that also uses the third bit. Half words at 0, 2, 4 and 6 and words at 0 and 4 show that the lane pairing follows `addr[1]` alone. Double words with distinct upper and lower halves expose a swapped or repeated half, and varying acknowledge delays with requests held high during busy periods show whether beats are held and whether extra requests leak in. Misaligned half, word and double-word addresses must produce only an error pulse.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2
    } seq_state_e;

    function automatic logic [2:0] size_code(xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'b001;
            SZ_HALF: return 3'b010;
            SZ_WORD: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/nbs_align_chk.sv
module nbs_align_chk
    import nbs_pkg::*;
(
    input  xfer_size_e size,
    input  logic [2:0] addr_lo,
    output logic       misaligned
);
    always_comb begin
        case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_HALF:  misaligned = addr_lo[0];
            SZ_WORD:  misaligned = |addr_lo[1:0];
            default:  misaligned = |addr_lo;
        endcase
    end
endmodule

// File: rtl/nbs_lane_map.sv
module nbs_lane_map
    import nbs_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int NARROW = 4
) (
    input  xfer_size_e             size,
    input  logic [2:0]             addr_lo,
    input  logic                   second_beat,
    input  logic [8*LANES-1:0]     wdata,
    output logic [LANES-1:0]       lane_en,
    output logic [8*LANES-1:0]     lane_data
);
    localparam int DW = 8 * LANES;
    localparam int NW = 8 * NARROW;

    int              first;
    int              cnt;
    logic [NW-1:0]   src;

    always_comb begin
        first = 0;
        cnt   = NARROW;
        src   = '0;
        case (size)
            SZ_BYTE: begin
                first    = int'(addr_lo[1:0]);
                cnt      = 1;
                src[7:0] = wdata[7:0];
            end
            SZ_HALF: begin
                first     = addr_lo[1] ? 2 : 0;
                cnt       = 2;
                src[15:0] = wdata[15:0];
            end
            SZ_WORD: begin
                src = wdata[NW-1:0];
            end
            default: begin
                src = second_beat ? wdata[NW-1:0] : wdata[2*NW-1:NW];
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < NARROW) begin : g_used
            logic       en_g;
            logic [7:0] byte_g;
            always_comb begin
                en_g   = 1'b0;
                byte_g = '0;
                if (g >= first && g < first + cnt) begin
                    en_g   = 1'b1;
                    byte_g = 8'(src >> (8 * (first + cnt - 1 - g)));
                end
            end
            assign lane_en[g]              = en_g;
            assign lane_data[DW-1-8*g -: 8] = byte_g;
        end else begin : g_off
            assign lane_en[g]              = 1'b0;
            assign lane_data[DW-1-8*g -: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/narrow_beat_seq.sv
module narrow_beat_seq
    import nbs_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 64,
    parameter int NARROW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              ready,
    output logic              bus_valid,
    output logic [2:0]        bus_tsiz,
    output logic [AW-1:0]     bus_addr,
    output logic [DW/8-1:0]   bus_lane_en,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              err
);
    localparam int LANES = DW / 8;

    typedef struct packed {
        seq_state_e      st;
        xfer_size_e      size;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic            done;
        logic            err;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    xfer_size_e in_size;
    logic       misaligned;
    logic [LANES-1:0] map_en;
    logic [DW-1:0]    map_data;

    assign in_size = xfer_size_e'(req_size);

    nbs_align_chk u_align (
        .size       (in_size),
        .addr_lo    (req_addr[2:0]),
        .misaligned (misaligned)
    );

    nbs_lane_map #(.LANES(LANES), .NARROW(NARROW)) u_map (
        .size        (ctl_q.size),
        .addr_lo     (ctl_q.addr[2:0]),
        .second_beat (ctl_q.st == ST_BEAT1),
        .wdata       (ctl_q.wdata),
        .lane_en     (map_en),
        .lane_data   (map_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.st    = ST_BEAT0;
                        ctl_d.size  = in_size;
                        ctl_d.addr  = req_addr;
                        ctl_d.wdata = req_wdata;
                    end
                end
            end
            ST_BEAT0: begin
                if (bus_ack) begin
                    if (ctl_q.size == SZ_DWORD) begin
                        ctl_d.st = ST_BEAT1;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: begin
                if (bus_ack) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready       = (ctl_q.st == ST_IDLE);
    assign bus_valid   = !ready;
    assign bus_tsiz    = size_code(ctl_q.size);
    assign bus_addr    = {ctl_q.addr[AW-1:3],
                          (ctl_q.size == SZ_DWORD) ? 3'b000 : ctl_q.addr[2:0]};
    assign bus_lane_en = bus_valid ? map_en : '0;
    assign bus_wdata   = bus_valid ? map_data : '0;
    assign done        = ctl_q.done;
    assign err         = ctl_q.err;

    // R7
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_tsiz) && $stable(bus_addr)
                                     && $stable(bus_lane_en) && $stable(bus_wdata)));

    // R6
    dword_second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BEAT0 && ctl_q.size == SZ_DWORD && bus_ack)
            |=> (bus_valid && bus_tsiz == 3'b000 && bus_addr[2:0] == 3'b000
                 && bus_lane_en[NARROW-1:0] == '1));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack && !(ctl_q.st == ST_BEAT0 && ctl_q.size == SZ_DWORD))
            |=> (done && ready && !bus_valid));

    // R9
    err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ready && !bus_valid && !done));

    // R3
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_tsiz == 3'b001) |-> ($countones(bus_lane_en) == 1));

    // R2
    high_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lane_en[LANES-1:NARROW] == '0);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !misaligned) |=> (!ready && bus_valid));
endmodule

// File: tb/sim_narrow_beat_seq.sv
module sim_narrow_beat_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [63:0] req_wdata;
    logic        ready, bus_valid, bus_ack, done, err;
    logic [2:0]  bus_tsiz;
    logic [31:0] bus_addr;
    logic [7:0]  bus_lane_en;
    logic [63:0] bus_wdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    narrow_beat_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .bus_valid(bus_valid), .bus_tsiz(bus_tsiz), .bus_addr(bus_addr),
        .bus_lane_en(bus_lane_en), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .done(done), .err(err)
    );

    // model state
    logic [2:0]  q_tsiz[$];
    logic [31:0] q_addr[$];
    logic [7:0]  q_en[$];
    logic [63:0] q_data[$];
    string       q_tag[$];
    logic        m_done = 1'b0;
    logic        m_err  = 1'b0;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push_beat(logic [2:0] t, logic [31:0] a, logic [7:0] e,
                             logic [63:0] d, string tag);
        q_tsiz.push_back(t); q_addr.push_back(a); q_en.push_back(e);
        q_data.push_back(d); q_tag.push_back(tag);
    endtask

    function automatic bit is_mis(logic [1:0] s, logic [31:0] a);
        case (s)
            2'd0: return 1'b0;
            2'd1: return a[0] != 1'b0;
            2'd2: return a[1:0] != 2'b00;
            default: return a[2:0] != 3'b000;
        endcase
    endfunction

    task automatic model_advance(logic v, logic [1:0] s, logic [31:0] a,
                                 logic [63:0] d, logic ack);
        int lane;
        m_done = 1'b0;
        m_err  = 1'b0;
        if (q_tsiz.size() > 0) begin
            if (ack) begin
                void'(q_tsiz.pop_front()); void'(q_addr.pop_front());
                void'(q_en.pop_front()); void'(q_data.pop_front());
                void'(q_tag.pop_front());
                if (q_tsiz.size() == 0) m_done = 1'b1;
            end
        end else if (v) begin
            if (is_mis(s, a)) begin
                m_err = 1'b1;
            end else begin
                case (s)
                    2'd0: begin
                        lane = int'(a[1:0]);
                        push_beat(3'b001, a, 8'(1 << lane),
                                  {d[7:0], 56'h0} >> (8 * lane), "R3");
                    end
                    2'd1: begin
                        lane = a[1] ? 2 : 0;
                        push_beat(3'b010, a, 8'(3 << lane),
                                  {d[15:0], 48'h0} >> (8 * lane), "R4");
                    end
                    2'd2: push_beat(3'b100, a, 8'h0F, {d[31:0], 32'h0}, "R5");
                    default: begin
                        push_beat(3'b000, {a[31:3], 3'b000}, 8'h0F, {d[63:32], 32'h0}, "R6");
                        push_beat(3'b000, {a[31:3], 3'b000}, 8'h0F, {d[31:0], 32'h0}, "R6");
                    end
                endcase
            end
        end
    endtask

    task automatic compare_now();
        if (q_tsiz.size() > 0) begin
            chk(bus_valid == 1'b1, "R7 bus_valid", 64'(bus_valid), 64'd1);
            chk(ready == 1'b0, "R10 ready", 64'(ready), 64'd0);
            chk(bus_tsiz == q_tsiz[0], "R1 bus_tsiz", 64'(bus_tsiz), 64'(q_tsiz[0]));
            chk(bus_addr == q_addr[0], {q_tag[0], " bus_addr"}, 64'(bus_addr), 64'(q_addr[0]));
            chk(bus_lane_en == q_en[0], {q_tag[0], " R2 bus_lane_en"}, 64'(bus_lane_en), 64'(q_en[0]));
            chk(bus_wdata == q_data[0], {q_tag[0], " bus_wdata"}, bus_wdata, q_data[0]);
        end else begin
            chk(bus_valid == 1'b0, "R10 bus_valid idle", 64'(bus_valid), 64'd0);
            chk(ready == 1'b1, "R10 ready idle", 64'(ready), 64'd1);
            chk(bus_lane_en == 8'h00, "R2 lane_en idle", 64'(bus_lane_en), 64'd0);
        end
        chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
        chk(err == m_err, "R9 err", 64'(err), 64'(m_err));
    endtask

    task automatic step(logic v, logic [1:0] s, logic [31:0] a, logic [63:0] d, logic ack);
        @(negedge clk);
        compare_now();
        req_valid = v; req_size = s; req_addr = a; req_wdata = d; bus_ack = ack;
        model_advance(v, s, a, d, ack);
    endtask

    task automatic run_req(logic [1:0] s, logic [31:0] a, logic [63:0] d,
                           int delay, bit busy_req);
        int cnt = 0;
        logic ack;
        step(1'b1, s, a, d, 1'b0);
        while (q_tsiz.size() > 0) begin
            ack = (cnt >= delay);
            step(busy_req, 2'd0, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, ack);
            cnt = ack ? 0 : cnt + 1;
        end
        step(1'b0, 2'd0, 32'h0, 64'h0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_size = 2'd0; req_addr = '0;
        req_wdata = '0; bus_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0 && err == 1'b0,
            "R10 reset state", {60'h0, ready, bus_valid, done, err}, 64'h8);

        // R3 bytes at every low address, R1 size code
        for (int i = 0; i < 8; i++)
            run_req(2'd0, 32'h0000_1000 + 32'(i), 64'h1122_3344_5566_7700 + 64'(i), i % 3, 1'b0);
        // R4 half words
        for (int i = 0; i < 8; i += 2)
            run_req(2'd1, 32'h0000_2000 + 32'(i), 64'h0000_0000_0000_A1B0 + 64'(i), 1, 1'b0);
        // R5 words
        run_req(2'd2, 32'h0000_3000, 64'hDEAD_BEEF_CAFE_F00D, 0, 1'b0);
        run_req(2'd2, 32'h0000_3004, 64'h0102_0304_0506_0708, 2, 1'b0);
        // R6 double words, R7 hold with delays, R10 busy requests ignored
        run_req(2'd3, 32'h0000_4000, 64'h0123_4567_89AB_CDEF, 0, 1'b0);
        run_req(2'd3, 32'h0000_4108, 64'hFEDC_BA98_7654_3210, 3, 1'b1);
        run_req(2'd1, 32'h0000_5002, 64'h0000_0000_0000_5A69, 4, 1'b1);
        // R9 misaligned requests
        run_req(2'd1, 32'h0000_6001, 64'h1, 0, 1'b0);
        run_req(2'd2, 32'h0000_6002, 64'h2, 0, 1'b0);
        run_req(2'd3, 32'h0000_6004, 64'h3, 0, 1'b0);
        run_req(2'd3, 32'h0000_6001, 64'h4, 0, 1'b0);
        // R8 back-to-back after done
        run_req(2'd2, 32'h0000_7000, 64'h0000_0000_7777_8888, 0, 1'b0);
        run_req(2'd0, 32'h0000_7007, 64'h0000_0000_0000_00E5, 0, 1'b0);
        step(1'b0, 2'd0, 32'h0, 64'h0, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule